// File: doc/BRIEF.md
# Request/Reply Input Queue with Reject Path

This block is the receive side of a node that takes both request and reply transactions from one shared network port. Each arriving packet carries a kind bit and a source identifier. The block steers the packet into one of two independent first-in first-out queues. The local request handler drains one queue and the local reply handler drains the other.

The network port is never stalled. Reply storage is reserved for every transaction the node may have outstanding, so a reply always fits. Request storage is sized for every other node's outstanding transactions. When a request arrives and finds the request queue full, it is discarded. The block then raises a one-cycle reject pulse that carries the requester's source identifier, so the sender can retry. Because a full request queue cannot block the input, the fetch-deadlock cycle between requests and replies cannot form.

Both queues report their occupancy and their empty and full state to the local handlers.

Top module: `rr_sink_queue`

## Requirements
- R1: A packet with `net_kind_i`=1 is a reply and enters only the reply queue; with `net_kind_i`=0 it is a request and enters only the request queue. Source and data are kept with the packet.
- R2: `net_ready_o` is 1 in every cycle out of reset, whatever the queues hold.
- R3: The request queue holds K*(P-1) entries and the reply queue holds K entries. With the defaults K=2 and P=8 these are 14 and 2.
- R4: A request that arrives while `req_full_o` is 1 is dropped. In the next cycle `nack_valid_o` is 1 for exactly one cycle, with `nack_src_o` equal to that request's source.
- R5: A reply is accepted while the request queue is full, and accepting it raises no reject.
- R6: Each queue presents a count of its entries, an empty flag (count 0) and a full flag (count at capacity).
- R7: Each queue delivers its entries in arrival order. The head is shown while valid is 1 and is removed on a cycle where ready is also 1.
- R8: After reset both queues are empty with counts of zero, and `nack_valid_o` is 0.
- R9: Fullness is judged before the cycle's dequeue. A request that arrives at a full request queue in the same cycle as a request dequeue is still rejected, and the dequeue still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| net_valid_i | input | 1 | A packet is present on the network port |
| net_ready_o | output | 1 | Port is accepting packets (always 1 out of reset) |
| net_kind_i | input | 1 | 1 = reply, 0 = request |
| net_src_i | input | SRC_W | Source node identifier |
| net_data_i | input | DATA_W | Packet payload |
| req_valid_o | output | 1 | The request queue has a head entry |
| req_ready_i | input | 1 | Request handler takes the head entry |
| req_src_o | output | SRC_W | Source of the request at the head |
| req_data_o | output | DATA_W | Payload of the request at the head |
| req_count_o | output | RQ_CW | Request queue occupancy |
| req_empty_o | output | 1 | Request queue is empty |
| req_full_o | output | 1 | Request queue is full |
| rpl_valid_o | output | 1 | The reply queue has a head entry |
| rpl_ready_i | input | 1 | Reply handler takes the head entry |
| rpl_src_o | output | SRC_W | Source of the reply at the head |
| rpl_data_o | output | DATA_W | Payload of the reply at the head |
| rpl_count_o | output | RP_CW | Reply queue occupancy |
| rpl_empty_o | output | 1 | Reply queue is empty |
| rpl_full_o | output | 1 | Reply queue is full |
| nack_valid_o | output | 1 | Reject pulse for a dropped request |
| nack_src_o | output | SRC_W | Source of the dropped request |

## Verification
The bench builds the block with its defaults, K=2 and P=8. This gives a 14-entry request queue and a 2-entry reply queue, so both can be filled to capacity within a few dozen cycles. The small reply depth makes the reply queue's full flag easy to reach. Filling the request queue makes the reject path reachable, both on its own and in the same cycle as a dequeue, and it allows a reply to be injected while requests are being refused. The non-power-of-two request depth also exercises pointer wrap at a boundary that is not a power of two.

// File: rtl/rr_sink_pkg.sv
package rr_sink_pkg;
  typedef enum logic {
    KIND_REQ = 1'b0,
    KIND_RPL = 1'b1
  } pkt_kind_e;

  function automatic int req_slots(int k, int p);
    return k * (p - 1);
  endfunction

  function automatic int rpl_slots(int k);
    return k;
  endfunction
endpackage

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  assign valid_o = !empty_o;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rr_nack_gen.sv
module rr_nack_gen #(
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reject_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             nack_valid_o,
  output logic [SRC_W-1:0] nack_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_valid_o <= 1'b0;
      nack_src_o   <= '0;
    end else begin
      nack_valid_o <= reject_i;
      if (reject_i) nack_src_o <= src_i;
    end
  end
endmodule

// File: rtl/rr_sink_queue.sv
module rr_sink_queue
  import rr_sink_pkg::*;
#(
  parameter int K      = 2,
  parameter int P      = 8,
  parameter int DATA_W = 16,
  localparam int SRC_W  = (P > 1) ? $clog2(P) : 1,
  localparam int RQ_D   = req_slots(K, P),
  localparam int RP_D   = rpl_slots(K),
  localparam int RQ_CW  = $clog2(RQ_D + 1),
  localparam int RP_CW  = $clog2(RP_D + 1),
  localparam int PKT_W  = SRC_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              net_valid_i,
  output logic              net_ready_o,
  input  logic              net_kind_i,
  input  logic [SRC_W-1:0]  net_src_i,
  input  logic [DATA_W-1:0] net_data_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [SRC_W-1:0]  req_src_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic [RQ_CW-1:0]  req_count_o,
  output logic              req_empty_o,
  output logic              req_full_o,
  output logic              rpl_valid_o,
  input  logic              rpl_ready_i,
  output logic [SRC_W-1:0]  rpl_src_o,
  output logic [DATA_W-1:0] rpl_data_o,
  output logic [RP_CW-1:0]  rpl_count_o,
  output logic              rpl_empty_o,
  output logic              rpl_full_o,
  output logic              nack_valid_o,
  output logic [SRC_W-1:0]  nack_src_o
);
  logic             is_req, is_rpl, reject;
  logic [PKT_W-1:0] pkt, req_head, rpl_head;

  // Input never stalls; overflowing requests go to the reject path.
  assign net_ready_o = 1'b1;
  assign pkt    = {net_src_i, net_data_i};
  assign is_req = net_valid_i && (pkt_kind_e'(net_kind_i) == KIND_REQ);
  assign is_rpl = net_valid_i && (pkt_kind_e'(net_kind_i) == KIND_RPL);
  assign reject = is_req && req_full_o;

  rr_fifo #(.DEPTH(RQ_D), .W(PKT_W)) u_req_q (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (is_req),
    .push_data_i (pkt),
    .pop_i       (req_ready_i),
    .valid_o     (req_valid_o),
    .head_o      (req_head),
    .count_o     (req_count_o),
    .empty_o     (req_empty_o),
    .full_o      (req_full_o)
  );

  rr_fifo #(.DEPTH(RP_D), .W(PKT_W)) u_rpl_q (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (is_rpl),
    .push_data_i (pkt),
    .pop_i       (rpl_ready_i),
    .valid_o     (rpl_valid_o),
    .head_o      (rpl_head),
    .count_o     (rpl_count_o),
    .empty_o     (rpl_empty_o),
    .full_o      (rpl_full_o)
  );

  rr_nack_gen #(.SRC_W(SRC_W)) u_nack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reject_i     (reject),
    .src_i        (net_src_i),
    .nack_valid_o (nack_valid_o),
    .nack_src_o   (nack_src_o)
  );

  assign {req_src_o, req_data_o} = req_head;
  assign {rpl_src_o, rpl_data_o} = rpl_head;
endmodule

// File: rtl/rr_sink_queue_chk.sv
module rr_sink_queue_chk #(
  parameter int SRC_W = 3,
  parameter int RQ_D  = 14,
  parameter int RP_D  = 2,
  parameter int RQ_CW = 4,
  parameter int RP_CW = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             net_valid_i,
  input logic             net_ready_o,
  input logic             net_kind_i,
  input logic [SRC_W-1:0] net_src_i,
  input logic             req_ready_i,
  input logic [RQ_CW-1:0] req_count_o,
  input logic             req_full_o,
  input logic [RP_CW-1:0] rpl_count_o,
  input logic             rpl_full_o,
  input logic             nack_valid_o,
  input logic [SRC_W-1:0] nack_src_o
);
  p_ready_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_ready_o);

  p_nack_on_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_i && !net_kind_i && req_full_o |=>
      nack_valid_o && nack_src_o == $past(net_src_i));

  p_no_spurious_nack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(net_valid_i && !net_kind_i && req_full_o) |=> !nack_valid_o);

  // Debug: a reply must never meet a full reply queue.
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_i && net_kind_i |-> !rpl_full_o);

  p_req_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_count_o <= RQ_CW'(RQ_D));

  p_rpl_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpl_count_o <= RP_CW'(RP_D));

  p_req_no_grow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(net_valid_i && !net_kind_i) |=> req_count_o <= $past(req_count_o));

  p_full_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_full_o && req_ready_i |=> !req_full_o);
endmodule

bind rr_sink_queue rr_sink_queue_chk #(
  .SRC_W(SRC_W), .RQ_D(RQ_D), .RP_D(RP_D), .RQ_CW(RQ_CW), .RP_CW(RP_CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .net_valid_i  (net_valid_i),
  .net_ready_o  (net_ready_o),
  .net_kind_i   (net_kind_i),
  .net_src_i    (net_src_i),
  .req_ready_i  (req_ready_i),
  .req_count_o  (req_count_o),
  .req_full_o   (req_full_o),
  .rpl_count_o  (rpl_count_o),
  .rpl_full_o   (rpl_full_o),
  .nack_valid_o (nack_valid_o),
  .nack_src_o   (nack_src_o)
);

// File: tb/rr_sink_queue_tb_top.sv
module rr_sink_queue_tb_top;
  localparam int K = 2, P = 8, DATA_W = 16;
  localparam int SRC_W = 3, RQ_D = 14, RP_D = 2, RQ_CW = 4, RP_CW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic net_valid_i = 0, net_kind_i = 0, req_ready_i = 0, rpl_ready_i = 0;
  logic [SRC_W-1:0] net_src_i = '0;
  logic [DATA_W-1:0] net_data_i = '0;
  logic net_ready_o, req_valid_o, req_empty_o, req_full_o;
  logic rpl_valid_o, rpl_empty_o, rpl_full_o, nack_valid_o;
  logic [SRC_W-1:0] req_src_o, rpl_src_o, nack_src_o;
  logic [DATA_W-1:0] req_data_o, rpl_data_o;
  logic [RQ_CW-1:0] req_count_o;
  logic [RP_CW-1:0] rpl_count_o;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rr_sink_queue #(.K(K), .P(P), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .net_valid_i(net_valid_i), .net_ready_o(net_ready_o), .net_kind_i(net_kind_i),
    .net_src_i(net_src_i), .net_data_i(net_data_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_src_o(req_src_o),
    .req_data_o(req_data_o), .req_count_o(req_count_o), .req_empty_o(req_empty_o),
    .req_full_o(req_full_o),
    .rpl_valid_o(rpl_valid_o), .rpl_ready_i(rpl_ready_i), .rpl_src_o(rpl_src_o),
    .rpl_data_o(rpl_data_o), .rpl_count_o(rpl_count_o), .rpl_empty_o(rpl_empty_o),
    .rpl_full_o(rpl_full_o),
    .nack_valid_o(nack_valid_o), .nack_src_o(nack_src_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one packet for one edge; outputs are settled on return.
  task automatic send(logic kind, logic [SRC_W-1:0] src, logic [DATA_W-1:0] d);
    @(negedge clk);
    net_valid_i = 1; net_kind_i = kind; net_src_i = src; net_data_i = d;
    @(negedge clk);
    net_valid_i = 0;
  endtask

  task automatic pop_req(string tag, logic [SRC_W-1:0] src, logic [DATA_W-1:0] d);
    chk({tag, " req valid"}, req_valid_o, 1);
    chk({tag, " req src"}, req_src_o, src);
    chk({tag, " req data"}, req_data_o, d);
    req_ready_i = 1;
    @(negedge clk);
    req_ready_i = 0;
  endtask

  task automatic pop_rpl(string tag, logic [SRC_W-1:0] src, logic [DATA_W-1:0] d);
    chk({tag, " rpl valid"}, rpl_valid_o, 1);
    chk({tag, " rpl src"}, rpl_src_o, src);
    chk({tag, " rpl data"}, rpl_data_o, d);
    rpl_ready_i = 1;
    @(negedge clk);
    rpl_ready_i = 0;
  endtask

  task automatic fill_req();
    for (int i = 0; i < RQ_D; i++) begin
      send(0, SRC_W'(i % P), DATA_W'(16'h100 + i));
      chk("R4 no nack while filling", nack_valid_o, 0);
      chk("R2 ready", net_ready_o, 1);
    end
  endtask

  task automatic t_reset();
    chk("R8 req count", req_count_o, 0);
    chk("R8 rpl count", rpl_count_o, 0);
    chk("R8 req empty", req_empty_o, 1);
    chk("R8 rpl empty", rpl_empty_o, 1);
    chk("R8 req full", req_full_o, 0);
    chk("R8 nack", nack_valid_o, 0);
    chk("R2 ready after reset", net_ready_o, 1);
  endtask

  task automatic t_sort();
    send(0, 3'd1, 16'h0011);
    send(1, 3'd2, 16'h0022);
    send(0, 3'd3, 16'h0033);
    chk("R1 req count", req_count_o, 2);
    chk("R1 rpl count", rpl_count_o, 1);
    chk("R6 req not empty", req_empty_o, 0);
    pop_req("R7 first", 3'd1, 16'h0011);
    pop_rpl("R1 reply", 3'd2, 16'h0022);
    pop_req("R7 second", 3'd3, 16'h0033);
    chk("R6 req empty after drain", req_empty_o, 1);
    chk("R6 rpl empty after drain", rpl_empty_o, 1);
  endtask

  task automatic t_full_reject();
    fill_req();
    chk("R3 req count at capacity", req_count_o, RQ_D);
    chk("R6 req full", req_full_o, 1);
    send(0, 3'd5, 16'hDEAD);
    chk("R4 nack raised", nack_valid_o, 1);
    chk("R4 nack src", nack_src_o, 5);
    chk("R4 dropped, count held", req_count_o, RQ_D);
    @(negedge clk);
    chk("R4 nack single cycle", nack_valid_o, 0);
    send(1, 3'd6, 16'h00AB);
    chk("R5 reply accepted while req full", rpl_count_o, 1);
    chk("R5 no nack for reply", nack_valid_o, 0);
    for (int i = 0; i < RQ_D; i++)
      pop_req("R7 order after fill", SRC_W'(i % P), DATA_W'(16'h100 + i));
    chk("R4 rejected request absent", req_valid_o, 0);
    pop_rpl("R5 reply content", 3'd6, 16'h00AB);
  endtask

  task automatic t_rpl_full();
    send(1, 3'd0, 16'h0A0A);
    chk("R6 rpl not full at 1", rpl_full_o, 0);
    send(1, 3'd7, 16'h0B0B);
    chk("R3 rpl count at capacity", rpl_count_o, RP_D);
    chk("R6 rpl full", rpl_full_o, 1);
    chk("R1 req untouched", req_count_o, 0);
    pop_rpl("R7 rpl first", 3'd0, 16'h0A0A);
    pop_rpl("R7 rpl second", 3'd7, 16'h0B0B);
    chk("R6 rpl empty", rpl_empty_o, 1);
  endtask

  task automatic t_full_pop_same();
    fill_req();
    @(negedge clk);
    net_valid_i = 1; net_kind_i = 0; net_src_i = 3'd4; net_data_i = 16'hBEEF;
    req_ready_i = 1;
    @(negedge clk);
    net_valid_i = 0; req_ready_i = 0;
    chk("R9 nack despite pop", nack_valid_o, 1);
    chk("R9 nack src", nack_src_o, 4);
    chk("R9 count after pop", req_count_o, RQ_D - 1);
    for (int i = 1; i < RQ_D; i++)
      pop_req("R9 remaining order", SRC_W'(i % P), DATA_W'(16'h100 + i));
    chk("R9 queue empty", req_empty_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_sort();
    t_full_reject();
    t_rpl_full();
    t_full_pop_same();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule